// File: doc/BRIEF.md
# Receiver Frequency Counter with IF Offset

This block turns a radio's local-oscillator signal into the frequency the receiver is tuned to, given as five BCD digits. Edges of the digitised oscillator input are counted inside a gate window. The window is timed by a reference clock that is nominally 7.2 MHz. Before each window opens, the counter is preset with the negative of the selected intermediate-frequency offset. When the window closes, the counter therefore already holds the received frequency. No subtraction is needed after the count.

The band input picks one of two modes:
- **FM mode.** The oscillator reaches the block already divided by eight. A 320 µs window makes every counted edge worth 25 kHz. The result is shown to 50 kHz resolution.
- **MW/LW mode.** A 1 ms window gives 1 kHz per edge. One offset code instead selects a 100 µs window and 10 kHz steps.

Measurements run back to back. A one-cycle strobe marks each new result. A 50 Hz square wave divided from the reference clock is also provided.

Top module: `rx_freq_counter`

## Requirements
- R1: While reset is held, and until the first measurement ends, `result_bcd` is 0, `result_valid` is 0, `result_fm` is 0 and `tb_50hz` is 0.
- R2: With `band_fm`=1 and N rising edges counted in one gate, the result is the received frequency in MHz as digits ddd.dd, with nibble [19:16] holding hundreds of MHz and nibble [3:0] holding tens of kHz. The value is N×25 kHz minus the signed offset. The 25 kHz part is truncated, so the last digit is 0 or 5.
- R3: `fm_if_sel` selects the FM offset in MHz: 000 +10.700, 001 +10.725, 010 +10.675, 011 +10.750, 100 −10.700, 101 −10.725, 110 −10.675, 111 −10.650.
- R4: With `band_fm`=0 and `am_if_sel` set to 00, 10 or 11, the offsets are +450, +455 and +469 kHz. The result is N kHz minus the offset, in five decimal kHz digits, with nibble [3:0] holding units of kHz.
- R5: With `band_fm`=0 and `am_if_sel`=01, each edge is worth 10 kHz and the offset is +450 kHz. Nibble [3:0] of the result is always 0.
- R6: Counts below the offset wrap instead of saturating. FM results are taken modulo 1000 MHz and MW/LW results modulo 100000 kHz.
- R7: `result_valid` is a one-cycle pulse once per measurement. Pulses are G+2 cycles apart, where G is REF_HZ×320 µs on FM, REF_HZ×1 ms on 1 kHz MW/LW and REF_HZ×100 µs on 10 kHz MW/LW. `result_bcd` changes only together with that pulse.
- R8: The band and offset inputs are sampled only in the cycle in which `result_valid` is high. Changing them at any other time does not alter the measurement in progress.
- R9: `tb_50hz` toggles every REF_HZ/100 reference cycles, starting from 0 at reset.
- R10: `result_fm` carries the band of the measurement that produced the current result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (REF_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_in | input | 1 | Digitised oscillator input (divided by 8 on FM), asynchronous |
| band_fm | input | 1 | 1 = FM, 0 = MW/LW |
| fm_if_sel | input | 3 | FM offset select code |
| am_if_sel | input | 2 | MW/LW offset and step select code |
| result_bcd | output | 20 | Five BCD digits of received frequency |
| result_fm | output | 1 | Band of the current result |
| result_valid | output | 1 | One-cycle strobe when a new result is latched |
| tb_50hz | output | 1 | 50 Hz square wave time base |

## Verification
Edge counts are drawn at random, together with random codes on both offset selects:
- **Sign and size of each offset.** The random draws check the sign and size of every offset entry, separately from the edge counting.
- **Wrap-around.** Zero counts with positive offsets show that the preset rolls over instead of clamping.
- **Offset in counter units.** A count that exactly cancels the 10 kHz offset shows that the offset is scaled to counter units.
- **Sampling point of the mode inputs.** Some measurements change the band and select inputs in the middle of the gate and restore them before the gate ends. The result must still follow the mode sampled at the start, which shows where the mode inputs are sampled.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  localparam int RES_DIGITS = 5;
  localparam int DIG_W      = 4;
  localparam int RES_W      = RES_DIGITS * DIG_W;

  typedef enum logic [1:0] {
    SEQ_LOAD = 2'd0,
    SEQ_GATE = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // Gate lengths in reference cycles.
  function automatic int fm_gate_cycles(int ref_hz);
    return (ref_hz / 25000) * 8;          // 320 us
  endfunction

  function automatic int am1_gate_cycles(int ref_hz);
    return ref_hz / 1000;                 // 1 ms
  endfunction

  function automatic int am10_gate_cycles(int ref_hz);
    return ref_hz / 10000;                // 100 us
  endfunction

  function automatic int tb_half_cycles(int ref_hz);
    return ref_hz / 100;                  // half period of 50 Hz
  endfunction

  // Signed IF offset in counter units (25 kHz on FM, 1 or 10 kHz otherwise).
  function automatic int if_offset_units(logic fm, logic [2:0] fsel, logic [1:0] asel);
    int mag;
    if (fm) begin
      case (fsel[1:0])
        2'b00:   mag = 428;
        2'b01:   mag = 429;
        2'b10:   mag = 427;
        default: mag = (fsel[2]) ? 426 : 430;
      endcase
      return fsel[2] ? -mag : mag;
    end
    case (asel)
      2'b00:   return 450;
      2'b01:   return 45;
      2'b10:   return 455;
      default: return 469;
    endcase
  endfunction

  // Counter preset: the negated offset, brought into the counter's modulus.
  function automatic logic [RES_W-1:0] preset_word(logic fm, logic [2:0] fsel, logic [1:0] asel);
    int off;
    int v;
    int modv;
    logic [RES_W-1:0] w;
    off  = if_offset_units(fm, fsel, asel);
    modv = fm ? 40000 : 100000;
    v    = (off > 0) ? (modv - off) : -off;
    w    = '0;
    if (fm) begin
      w[DIG_W-1:0] = DIG_W'(v % 4);
      v = v / 4;
      for (int i = 1; i < RES_DIGITS; i++) begin
        w[i*DIG_W +: DIG_W] = DIG_W'(v % 10);
        v = v / 10;
      end
    end else begin
      for (int i = 0; i < RES_DIGITS; i++) begin
        w[i*DIG_W +: DIG_W] = DIG_W'(v % 10);
        v = v / 10;
      end
    end
    return w;
  endfunction

  // Raw counter digits to the result layout.
  function automatic logic [RES_W-1:0] shape_result(logic fm, logic step10, logic [RES_W-1:0] raw);
    if (fm)
      return {raw[RES_W-1:DIG_W], (raw[1] ? 4'd5 : 4'd0)};
    else if (step10)
      return {raw[RES_W-DIG_W-1:0], 4'd0};
    else
      return raw;
  endfunction

endpackage

// File: rtl/rfc_lo_sync.sv
module rfc_lo_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_in,
  output logic lo_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= lo_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lo_rise = sync_q & ~prev_q;
endmodule

// File: rtl/rfc_gate_seq.sv
module rfc_gate_seq import rfc_pkg::*; #(
  parameter int G_FM   = 2304,
  parameter int G_AM1  = 7200,
  parameter int G_AM10 = 720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic band_fm,
  input  logic step10,
  output logic load,
  output logic gate_open,
  output logic done
);
  localparam int G_MAX = (G_FM > G_AM1) ? ((G_FM > G_AM10) ? G_FM : G_AM10)
                                        : ((G_AM1 > G_AM10) ? G_AM1 : G_AM10);
  localparam int CW    = $clog2(G_MAX + 1);

  seq_state_e    state_q;
  logic [CW-1:0] gcnt_q;
  logic [CW-1:0] glen_m1;

  always_comb begin
    if (band_fm)     glen_m1 = CW'(G_FM - 1);
    else if (step10) glen_m1 = CW'(G_AM10 - 1);
    else             glen_m1 = CW'(G_AM1 - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_LOAD;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        SEQ_LOAD: begin
          gcnt_q  <= glen_m1;
          state_q <= SEQ_GATE;
        end
        SEQ_GATE: begin
          if (gcnt_q == '0) state_q <= SEQ_DONE;
          else              gcnt_q  <= gcnt_q - 1'b1;
        end
        default: state_q <= SEQ_LOAD;
      endcase
    end
  end

  assign load      = (state_q == SEQ_LOAD);
  assign gate_open = (state_q == SEQ_GATE);
  assign done      = (state_q == SEQ_DONE);
endmodule

// File: rtl/rfc_bcd_chain.sv
module rfc_bcd_chain #(
  parameter int DIGITS = 5,
  parameter int DW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DIGITS*DW-1:0] preset,
  input  logic                 inc,
  input  logic                 quarter_lsd,
  output logic [DIGITS*DW-1:0] count
);
  wire [DIGITS:0] carry;
  assign carry[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DW-1:0] dig_q;
    wire  [DW-1:0] top_val = (g == 0 && quarter_lsd) ? DW'(3) : DW'(9);
    wire           at_top  = (dig_q == top_val);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig_q <= '0;
      else if (load)     dig_q <= preset[g*DW +: DW];
      else if (carry[g]) dig_q <= at_top ? '0 : dig_q + 1'b1;
    end

    assign carry[g+1]         = carry[g] & at_top;
    assign count[g*DW +: DW]  = dig_q;
  end
endmodule

// File: rtl/rfc_timebase.sv
module rfc_timebase #(
  parameter int HALF = 72000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tb_out
);
  localparam int CW = $clog2(HALF);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tb_out <= 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q  <= '0;
      tb_out <= ~tb_out;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_freq_counter.sv
module rx_freq_counter import rfc_pkg::*; #(
  parameter int REF_HZ = 7_200_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_in,
  input  logic             band_fm,
  input  logic [2:0]       fm_if_sel,
  input  logic [1:0]       am_if_sel,
  output logic [RES_W-1:0] result_bcd,
  output logic             result_fm,
  output logic             result_valid,
  output logic             tb_50hz
);
  localparam int G_FM    = fm_gate_cycles(REF_HZ);
  localparam int G_AM1   = am1_gate_cycles(REF_HZ);
  localparam int G_AM10  = am10_gate_cycles(REF_HZ);
  localparam int TB_HALF = tb_half_cycles(REF_HZ);

  logic             lo_rise;
  logic             seq_load, gate_open, seq_done;
  logic             live_step10;
  logic             cur_fm, cur_step10;
  logic             lat_step10;
  logic [RES_W-1:0] preset_val;
  logic [RES_W-1:0] raw_count;
  logic             count_en;

  assign live_step10 = ~band_fm & (am_if_sel == 2'b01);
  assign count_en    = gate_open & lo_rise;

  always_comb preset_val = preset_word(band_fm, fm_if_sel, am_if_sel);

  rfc_lo_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_in   (lo_in),
    .lo_rise (lo_rise)
  );

  rfc_gate_seq #(.G_FM(G_FM), .G_AM1(G_AM1), .G_AM10(G_AM10)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .band_fm   (band_fm),
    .step10    (live_step10),
    .load      (seq_load),
    .gate_open (gate_open),
    .done      (seq_done)
  );

  rfc_bcd_chain #(.DIGITS(RES_DIGITS), .DW(DIG_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (seq_load),
    .preset      (preset_val),
    .inc         (count_en),
    .quarter_lsd (cur_fm),
    .count       (raw_count)
  );

  rfc_timebase #(.HALF(TB_HALF)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tb_out (tb_50hz)
  );

  // Mode of the measurement in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fm     <= 1'b0;
      cur_step10 <= 1'b0;
    end else if (seq_load) begin
      cur_fm     <= band_fm;
      cur_step10 <= live_step10;
    end
  end

  // Result register and strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_bcd   <= '0;
      result_fm    <= 1'b0;
      lat_step10   <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= seq_done;
      if (seq_done) begin
        result_bcd <= shape_result(cur_fm, cur_step10, raw_count);
        result_fm  <= cur_fm;
        lat_step10 <= cur_step10;
      end
    end
  end
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker import rfc_pkg::*; #(
  parameter int REF_HZ = 7_200_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] result_bcd,
  input logic             result_fm,
  input logic             result_valid,
  input logic             tb_50hz,
  input logic             lat_step10
);
  localparam int G_FM    = fm_gate_cycles(REF_HZ);
  localparam int G_AM1   = am1_gate_cycles(REF_HZ);
  localparam int G_AM10  = am10_gate_cycles(REF_HZ);
  localparam int TB_HALF = tb_half_cycles(REF_HZ);

  logic [31:0] gap_q, tb_cnt_q;
  logic        tb_q;
  logic        tb_toggled;
  int          exp_gap;
  logic        digits_ok;

  assign tb_toggled = (tb_50hz != tb_q);

  always_comb begin
    exp_gap = (result_fm ? G_FM : (lat_step10 ? G_AM10 : G_AM1)) + 2;
    digits_ok = 1'b1;
    for (int i = 0; i < RES_DIGITS; i++)
      if (result_bcd[i*DIG_W +: DIG_W] > 4'd9) digits_ok = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      tb_cnt_q <= '0;
      tb_q     <= 1'b0;
    end else begin
      gap_q    <= result_valid ? 32'd1 : gap_q + 32'd1;
      tb_cnt_q <= tb_toggled ? 32'd1 : tb_cnt_q + 32'd1;
      tb_q     <= tb_50hz;
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result_bcd));

  p_valid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (gap_q == 32'(exp_gap)));

  p_fm_half_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_fm) |-> (result_bcd[3:0] == 4'd0 || result_bcd[3:0] == 4'd5));

  p_am_tenk_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !result_fm && lat_step10) |-> (result_bcd[3:0] == 4'd0));

  p_bcd_digits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> digits_ok);

  p_tb_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tb_toggled |-> (tb_cnt_q == 32'(TB_HALF)));

  p_tb_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tb_cnt_q <= 32'(TB_HALF));
endmodule

bind rx_freq_counter rfc_checker #(.REF_HZ(REF_HZ)) u_rfc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .result_bcd   (result_bcd),
  .result_fm    (result_fm),
  .result_valid (result_valid),
  .tb_50hz      (tb_50hz),
  .lat_step10   (lat_step10)
);

// File: tb/rx_freq_counter_bench.sv
`timescale 1ns/1ps
module rx_freq_counter_bench;
  localparam int REF_HZ  = 3_200_000;
  localparam int G_FM    = 1024;
  localparam int G_AM1   = 3200;
  localparam int G_AM10  = 320;
  localparam int TB_HALF = 32000;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_in = 1'b0;
  logic        band_fm = 1'b1;
  logic [2:0]  fm_if_sel = 3'd0;
  logic [1:0]  am_if_sel = 2'd0;
  logic [19:0] result_bcd;
  logic        result_fm, result_valid, tb_50hz;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int rel_cyc = 0;
  bit tb_done = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rx_freq_counter #(.REF_HZ(REF_HZ)) u_rx_freq_counter (
    .clk, .rst_n, .lo_in, .band_fm, .fm_if_sel, .am_if_sel,
    .result_bcd, .result_fm, .result_valid, .tb_50hz
  );

  task automatic check_val(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int to_bcd(int x);
    int r = 0;
    for (int i = 0; i < 5; i++) begin
      r = r | ((x % 10) << (4 * i));
      x = x / 10;
    end
    return r;
  endfunction

  // Expected value restated from the offset tables, in display units.
  function automatic int expect_word(bit fm, int fsel, int asel, int n);
    int fm_mag[8] = '{428, 429, 427, 430, 428, 429, 427, 426};
    int am_khz[4] = '{450, 450, 455, 469};
    int v;
    if (fm) begin
      v = n - ((fsel >= 4) ? -fm_mag[fsel] : fm_mag[fsel]);
      v = ((v % 40000) + 40000) % 40000;           // 25 kHz units
      return to_bcd(((v / 2) * 5) % 100000);       // 10 kHz units, 50 kHz steps
    end
    if (asel == 1) begin
      v = n - am_khz[1] / 10;
      v = ((v % 100000) + 100000) % 100000;
      return to_bcd((v * 10) % 100000);
    end
    v = n - am_khz[asel];
    return to_bcd(((v % 100000) + 100000) % 100000);
  endfunction

  task automatic wait_valid();
    @(negedge clk);
    while (!result_valid) @(negedge clk);
  endtask

  // Called at the negedge where result_valid is high (the sampling cycle).
  task automatic measure(string req, bit fm, int fsel, int asel, int n, bit disturb);
    int t0, glen;
    band_fm   = fm;
    fm_if_sel = 3'(fsel);
    am_if_sel = 2'(asel);
    t0 = cyc;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      lo_in = 1'b1; @(negedge clk);
      lo_in = 1'b0; @(negedge clk);
    end
    if (disturb) begin   // R8: changes mid-gate must be ignored
      band_fm   = ~fm;
      fm_if_sel = ~3'(fsel);
      am_if_sel = ~2'(asel);
      repeat (4) @(negedge clk);
      band_fm   = fm;
      fm_if_sel = 3'(fsel);
      am_if_sel = 2'(asel);
    end
    wait_valid();
    glen = fm ? G_FM : ((asel == 1) ? G_AM10 : G_AM1);
    check_val({req, " value"}, int'(result_bcd), expect_word(fm, fsel, asel, n));
    check_val("R10 band flag", int'(result_fm), int'(fm));
    check_val("R7 strobe spacing", cyc - t0, glen + 2);
    @(negedge clk);
    check_val("R7 strobe single", int'(result_valid), 0);
    // Return at the next strobe so inputs are set in its sampling cycle.
    wait_valid();
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc == WATCHDOG && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // R9: time base watcher
  initial begin
    int last_t;
    logic last_v;
    wait (rst_n);
    last_t = rel_cyc;
    last_v = tb_50hz;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      while (tb_50hz == last_v) @(negedge clk);
      check_val("R9 half period", cyc - last_t, TB_HALF);
      last_t = cyc;
      last_v = tb_50hz;
    end
    tb_done = 1;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check_val("R1 reset result", int'(result_bcd), 0);
    check_val("R1 reset valid", int'(result_valid), 0);
    check_val("R1 reset band flag", int'(result_fm), 0);
    check_val("R1 reset timebase", int'(tb_50hz), 0);
    rel_cyc = cyc;
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 after release", int'(result_bcd), 0);
    wait_valid();

    // Directed corners
    measure("R6 R3 fm wrap +10.700", 1'b1, 0, 0, 0, 1'b0);
    measure("R3 fm -10.650", 1'b1, 7, 0, 500, 1'b0);
    measure("R2 fm 25k truncation", 1'b1, 1, 0, 431, 1'b0);
    measure("R6 R4 am wrap +469", 1'b0, 0, 3, 0, 1'b0);
    measure("R5 am 10k cancel", 1'b0, 0, 1, 45, 1'b0);
    measure("R4 am 1000 kHz", 1'b0, 0, 2, 1455, 1'b0);
    measure("R8 fm disturbed", 1'b1, 5, 0, 300, 1'b1);
    measure("R8 am disturbed", 1'b0, 0, 1, 120, 1'b1);

    // Random FM
    for (int k = 0; k < 8; k++)
      measure("R2 R3 fm random", 1'b1, int'($urandom % 8), 0, int'($urandom % 501), 1'b0);
    // Random MW/LW
    for (int k = 0; k < 8; k++) begin
      int a = int'($urandom % 4);
      int n = (a == 1) ? int'($urandom % 151) : int'($urandom % 1561);
      measure((a == 1) ? "R5 am10 random" : "R4 am random", 1'b0, 0, a, n, 1'b0);
    end

    while (!tb_done) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule